// File: doc/BRIEF.md
# Serial-Port FIFO DMA Request Generator

This block sits beside the receive and transmit FIFOs of a synchronous serial port and turns their fill levels into handshake requests for a DMA controller. Each direction has two request lines. A single-transfer request asks for one item. A burst-transfer request asks for a block of four items. The receive side looks at how many entries are waiting to be read. The transmit side looks at how many slots are free to be written.

The DMA controller withdraws a direction's requests by pulsing that direction's clear input. During a burst, it pulses the clear together with the last item of the burst, not on every item. A two-bit control register enables each direction on its own. It is loaded through a one-cycle write strobe. Every request output is a flop that starts low after a synchronous active-high reset.

The FIFO depth and the burst size are parameters. The defaults are a depth of 8 and a burst of 4, which gives 4-bit level inputs that count from 0 to 8.

Top module: `dreq_gen`

## Requirements
- R1: With receive DMA enabled and no receive clear, `rxSingleReq` is high in the cycle after any clock edge at which `rxLevel` is 1 or more; otherwise it is low.
- R2: With receive DMA enabled and no receive clear, `rxBurstReq` is high in the cycle after any edge at which `rxLevel` is at least BURST (4); otherwise it is low.
- R3: With transmit DMA enabled and no transmit clear, `txSingleReq` is high after any edge at which the free space DEPTH - `txLevel` is 1 or more; otherwise it is low.
- R4: With transmit DMA enabled and no transmit clear, `txBurstReq` is high after any edge at which DEPTH - `txLevel` is at least BURST (4); otherwise it is low.
- R5: When `rxClear` is high at an edge, both receive requests are low in the following cycle. When `txClear` is high at an edge, both transmit requests are low in the following cycle. A clear on one direction leaves the other direction's requests untouched.
- R6: Once a clear input has returned low, that direction's requests reassert at the next edge if their level condition still holds. No extra idle cycle is inserted.
- R7: Writing `cfgWrData` with `cfgWrEn` high loads the enable register. Bit 0 is the receive enable and bit 1 is the transmit enable. The new value governs the requests from the edge after the write edge. A direction whose enable is 0 never asserts either of its requests.
- R8: Synchronous reset drives all four requests low and clears both enable bits.
- R9: A burst request is never high while the single request of the same direction is low.
- R10: A level input above DEPTH is treated as DEPTH. For example, `rxLevel` 12 counts as a full receive FIFO, and `txLevel` 15 counts as no free space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Write strobe for the enable register |
| cfgWrData | input | 2 | Enable value: bit 0 receive, bit 1 transmit |
| rxLevel | input | LVL_W (4) | Entries waiting in the receive FIFO |
| txLevel | input | LVL_W (4) | Entries held in the transmit FIFO |
| rxClear | input | 1 | Receive request clear from the DMA controller |
| txClear | input | 1 | Transmit request clear from the DMA controller |
| rxSingleReq | output | 1 | Receive single-transfer request |
| rxBurstReq | output | 1 | Receive burst-transfer request |
| txSingleReq | output | 1 | Transmit single-transfer request |
| txBurstReq | output | 1 | Transmit burst-transfer request |

## Verification
The assertions check four properties on every cycle:
- a clear always empties its own direction's requests on the next cycle;
- a burst request never stands without its single request;
- a disabled direction stays quiet;
- the enable register loads on a write and otherwise holds, and a released clear lets a pending request come straight back.

The bench scenarios are the only way to show two further properties. The first is that the thresholds land exactly on 1 and 4 for receive and on free space for transmit. The second is that the enable bits take effect one edge late, with out-of-range levels saturating. A reference model driven by random levels, clears and enable writes then compares every request line against those rules.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  // Strobes handed from the control module to the datapath each cycle.
  typedef struct packed {
    logic rxEn;   // receive direction enabled (registered)
    logic txEn;   // transmit direction enabled (registered)
    logic rxClr;  // receive clear from DMA controller
    logic txClr;  // transmit clear from DMA controller
  } dreqStrobe_t;

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int NUM_DIR = 2;

endpackage

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgWrData,
  input  logic        rxClear,
  input  logic        txClear,
  output dreqStrobe_t strobe
);

  logic [NUM_DIR-1:0] enReg;

  // Enable register: bit DIR_RX receive, bit DIR_TX transmit.
  always_ff @(posedge clk) begin
    if (rst) begin
      enReg <= '0;
    end else if (cfgWrEn) begin
      enReg <= cfgWrData;
    end
  end

  always_comb begin
    strobe.rxEn  = enReg[DIR_RX];
    strobe.txEn  = enReg[DIR_TX];
    strobe.rxClr = rxClear;
    strobe.txClr = txClear;
  end

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> (enReg == $past(cfgWrData))); // R7
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfgWrEn |=> $stable(enReg)); // R7

endmodule

// File: rtl/dreq_chan.sv
module dreq_chan #(
  parameter int DEPTH      = 8,
  parameter int BURST      = 4,
  parameter bit COUNT_FREE = 1'b0,
  localparam int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [LVL_W-1:0] level,
  output logic             singleReq,
  output logic             burstReq
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);

  logic [LVL_W-1:0] clamped;
  logic [LVL_W-1:0] avail;
  logic             singleNext;
  logic             burstNext;

  always_comb begin
    clamped = (level > DEPTH_L) ? DEPTH_L : level;
  end

  // Receive counts filled entries, transmit counts free slots.
  generate
    if (COUNT_FREE) begin : g_free
      always_comb avail = DEPTH_L - clamped;
    end else begin : g_fill
      always_comb avail = clamped;
    end
  endgenerate

  always_comb begin
    singleNext = en && !clr && (avail != '0);
    burstNext  = en && !clr && (avail >= BURST_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      singleReq <= 1'b0;
      burstReq  <= 1'b0;
    end else begin
      singleReq <= singleNext;
      burstReq  <= burstNext;
    end
  end

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!singleReq && !burstReq)); // R5
  AST_BURST_NEEDS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    burstReq |-> singleReq); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!singleReq && !burstReq)); // R7
  AST_REASSERT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !clr && en && (level != '0) && !COUNT_FREE) |=> singleReq); // R6

endmodule

// File: rtl/dreq_datapath.sv
module dreq_datapath
  import dreq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BURST  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  dreqStrobe_t      strobe,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  output logic [NUM_DIR-1:0] singleReq,
  output logic [NUM_DIR-1:0] burstReq
);

  logic [NUM_DIR-1:0] dirEn;
  logic [NUM_DIR-1:0] dirClr;
  logic [LVL_W-1:0]   dirLevel [NUM_DIR];

  always_comb begin
    dirEn[DIR_RX]    = strobe.rxEn;
    dirEn[DIR_TX]    = strobe.txEn;
    dirClr[DIR_RX]   = strobe.rxClr;
    dirClr[DIR_TX]   = strobe.txClr;
    dirLevel[DIR_RX] = rxLevel;
    dirLevel[DIR_TX] = txLevel;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    dreq_chan #(
      .DEPTH     (DEPTH),
      .BURST     (BURST),
      .COUNT_FREE(d == DIR_TX)
    ) i_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (dirEn[d]),
      .clr      (dirClr[d]),
      .level    (dirLevel[d]),
      .singleReq(singleReq[d]),
      .burstReq (burstReq[d])
    );
  end

endmodule

// File: rtl/dreq_gen.sv
module dreq_gen
  import dreq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BURST  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgWrData,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             rxClear,
  input  logic             txClear,
  output logic             rxSingleReq,
  output logic             rxBurstReq,
  output logic             txSingleReq,
  output logic             txBurstReq
);

  dreqStrobe_t        strobe;
  logic [NUM_DIR-1:0] singleReq;
  logic [NUM_DIR-1:0] burstReq;

  dreq_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .rxClear  (rxClear),
    .txClear  (txClear),
    .strobe   (strobe)
  );

  dreq_datapath #(
    .DEPTH(DEPTH),
    .BURST(BURST)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rxLevel  (rxLevel),
    .txLevel  (txLevel),
    .singleReq(singleReq),
    .burstReq (burstReq)
  );

  assign rxSingleReq = singleReq[DIR_RX];
  assign rxBurstReq  = burstReq[DIR_RX];
  assign txSingleReq = singleReq[DIR_TX];
  assign txBurstReq  = burstReq[DIR_TX];

  AST_CLEAR_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (rxClear && !txClear && strobe.txEn && (txLevel == '0)) |=> txBurstReq); // R5

endmodule

// File: tb/test_dreq_gen.sv
module test_dreq_gen;

  localparam int DEPTH = 8;
  localparam int BURST = 4;
  localparam int NVEC  = 19;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgWrData = 2'b00;
  logic [3:0] rxLevel = 4'd0;
  logic [3:0] txLevel = 4'd0;
  logic       rxClear = 1'b0;
  logic       txClear = 1'b0;
  logic       rxSingleReq, rxBurstReq, txSingleReq, txBurstReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dreq_gen i_dreq_gen (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .rxLevel(rxLevel), .txLevel(txLevel), .rxClear(rxClear), .txClear(txClear),
    .rxSingleReq(rxSingleReq), .rxBurstReq(rxBurstReq),
    .txSingleReq(txSingleReq), .txBurstReq(txBurstReq)
  );

  // Vector: {wr, wdata[1:0], rxLevel, txLevel, rxClr, txClr, expected {rxS,rxB,txS,txB}}
  // expected is sampled after the edge at which the vector is applied.
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 2'd3, 4'd5,  4'd0,  1'b0, 1'b0, 4'b0000}, // R7 enable not yet active
    {1'b0, 2'd0, 4'd5,  4'd0,  1'b0, 1'b0, 4'b1111}, // R1 R2 R3 R4
    {1'b0, 2'd0, 4'd1,  4'd7,  1'b0, 1'b0, 4'b1010}, // R1 R3 lower threshold
    {1'b0, 2'd0, 4'd0,  4'd8,  1'b0, 1'b0, 4'b0000}, // R1 R3 empty/full
    {1'b0, 2'd0, 4'd4,  4'd4,  1'b0, 1'b0, 4'b1111}, // R2 R4 burst threshold
    {1'b0, 2'd0, 4'd3,  4'd5,  1'b0, 1'b0, 4'b1010}, // R2 R4 just below burst
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b1, 1'b0, 4'b0011}, // R5 rx clear only
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b0, 1'b1, 4'b1100}, // R5 R6 tx clear, rx back
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b1, 1'b1, 4'b0000}, // R5 both clears
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b0, 1'b0, 4'b1111}, // R6 reassert
    {1'b1, 2'd1, 4'd6,  4'd2,  1'b0, 1'b0, 4'b1111}, // R7 write rx only
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b0, 1'b0, 4'b1100}, // R7 tx disabled
    {1'b1, 2'd2, 4'd6,  4'd2,  1'b0, 1'b0, 4'b1100}, // R7 write tx only
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b0, 1'b0, 4'b0011}, // R7 rx disabled
    {1'b1, 2'd0, 4'd6,  4'd2,  1'b0, 1'b0, 4'b0011}, // R7 disable both
    {1'b0, 2'd0, 4'd6,  4'd2,  1'b0, 1'b0, 4'b0000}, // R7 both quiet
    {1'b1, 2'd3, 4'd12, 4'd15, 1'b0, 1'b0, 4'b0000}, // R7 re-enable
    {1'b0, 2'd0, 4'd12, 4'd15, 1'b0, 1'b0, 4'b1100}, // R10 saturation
    {1'b0, 2'd0, 4'd12, 4'd0,  1'b0, 1'b0, 4'b1111}  // R10 rx saturated, tx empty
  };

  function automatic string bitName(int b);
    case (b)
      3: return "R1 rxSingleReq";
      2: return "R2 rxBurstReq";
      1: return "R3 txSingleReq";
      default: return "R4 txBurstReq";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {rxSingleReq, rxBurstReq, txSingleReq, txBurstReq};
    for (int b = 3; b >= 0; b--) begin
      checks++;
      if (act[b] !== exp[b]) begin
        errors++;
        $display("FAIL %s %s actual %0b expected %0b", tag, bitName(b), act[b], exp[b]);
      end
    end
    checks++;
    if ((rxBurstReq && !rxSingleReq) || (txBurstReq && !txSingleReq)) begin
      errors++;
      $display("FAIL %s R9 burst without single actual %b expected no burst alone", tag, act);
    end
  endtask

  // Reference model state.
  logic [1:0] enModel = 2'b00;

  function automatic logic [3:0] model(input logic [1:0] en, input logic [3:0] rl,
                                       input logic [3:0] tl, input logic rc, input logic tc);
    int r, f;
    r = (rl > DEPTH) ? DEPTH : rl;
    f = DEPTH - ((tl > DEPTH) ? DEPTH : tl);
    model = {en[0] && !rc && r >= 1, en[0] && !rc && r >= BURST,
             en[1] && !tc && f >= 1, en[1] && !tc && f >= BURST};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] exp;
    repeat (3) @(negedge clk);
    checkOut("R8 reset", 4'b0000);
    rst = 1'b0;
    @(negedge clk);

    // Table walk.
    for (int i = 0; i < NVEC; i++) begin
      {cfgWrEn, cfgWrData, rxLevel, txLevel, rxClear, txClear} = VEC[i][16:4];
      @(posedge clk);
      @(negedge clk);
      checkOut($sformatf("vec %0d", i), VEC[i][3:0]);
    end
    cfgWrEn = 1'b0;
    enModel = 2'b11;

    // Burst clear on last item: only final item clears (R5 R6).
    rxLevel = 4'd7; rxClear = 1'b0; txLevel = 4'd8; txClear = 1'b0;
    @(posedge clk); @(negedge clk);
    checkOut("R2 burst pending", 4'b1100);
    rxLevel = 4'd4; rxClear = 1'b1;
    @(posedge clk); @(negedge clk);
    checkOut("R5 clear on last burst item", 4'b0000);
    rxLevel = 4'd3; rxClear = 1'b0;
    @(posedge clk); @(negedge clk);
    checkOut("R6 single only after clear", 4'b1000);

    // Random phase against reference model.
    for (int n = 0; n < 3000; n++) begin
      cfgWrEn   = ($urandom_range(0, 19) == 0);
      cfgWrData = 2'($urandom_range(0, 3));
      rxLevel   = 4'($urandom_range(0, DEPTH));
      txLevel   = 4'($urandom_range(0, DEPTH));
      rxClear   = ($urandom_range(0, 3) == 0);
      txClear   = ($urandom_range(0, 3) == 0);
      exp = model(enModel, rxLevel, txLevel, rxClear, txClear);
      if (cfgWrEn) enModel = cfgWrData;
      @(posedge clk); @(negedge clk);
      checkOut($sformatf("random %0d R5 R6 R7", n), exp);
    end

    // Reset mid-activity clears outputs and enables (R8).
    cfgWrEn = 1'b0; rxClear = 1'b0; txClear = 1'b0;
    rxLevel = 4'd8; txLevel = 4'd0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checkOut("R8 reset during traffic", 4'b0000);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkOut("R8 enables cleared by reset", 4'b0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule